// File: doc/BRIEF.md
# Hash-Chained Session Lookup Engine

The engine resolves the flow key of one packet against a session table held in slow external memory. A request carries a 104-bit flow key, made of source address, destination address, source port, destination port and protocol. The engine hashes the key with a CRC-32 and uses the low 16 bits as a bucket address. It then follows the collision chain from that bucket, fetching one table entry per memory transaction. It stops when a stored key equals the request key or when the chain runs out.

On a key match, the engine bumps the session's hit counter, writes the entry back to memory and reports a hit along with the updated state. If the chain ends with no match, it reports a miss so that the packet can go to the classifier, and it issues no write. A walk that reaches its read budget without an answer is stopped and flagged as an error, which guards against a looped chain. The engine handles one packet at a time. Its memory port is a valid/ready request channel plus a response strobe, so read and write latencies can vary. Every result also reports how many chain reads were used.

Top module: `sessionLookup`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `doneValid` and `memReqValid` are low until a request arrives. When idle, the engine never drives a memory request.
- R2: The first memory read of a lookup targets the bucket address. This is the low 16 bits of the reflected CRC-32 of the key, computed with polynomial 0xEDB88320, a preset of all ones and a final inversion. The key is fed from bit 0 upward, and the result is zero-extended to the 20-bit address.
- R3: An entry is 141 bits wide. Bit 140 is valid, bits 139:36 hold the key, bits 35:20 hold the state and bits 19:0 hold the next pointer. The engine reads the entry at the next pointer whenever the current entry is valid, has a different key and has a non-zero next pointer.
- R4: When a valid entry's key equals the request key, the engine writes that entry back to the same address with only the state changed. It then reports `doneHit` with the updated state on `doneState`.
- R5: The state update increments state bits 11:0, saturating at 0xFFF, and leaves bits 15:12 unchanged.
- R6: A cleared valid bit, or a non-matching entry whose next pointer is zero, ends the walk with `doneMiss` and no memory write.
- R7: If read number 8 neither matches nor ends the chain, the walk stops with `doneErr`, reports 8 reads and performs no write. A match on read 8 still counts as a hit.
- R8: A memory request holds its valid, address and direction stable until `memReqReady` is seen. The engine waits for `memRspValid` after every request, whether read or write, before it moves on.
- R9: `doneValid` is a one-cycle pulse, and exactly one of `doneHit`, `doneMiss` and `doneErr` is high with it. `busy` then falls on the next cycle.
- R10: `doneReads` equals the number of table reads issued for the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a lookup (taken when not busy) |
| reqKey | input | 104 | Flow key of the packet |
| busy | output | 1 | Lookup in progress |
| memReqValid | output | 1 | Memory request valid |
| memReqWrite | output | 1 | Request is a write (else read) |
| memReqAddr | output | 20 | Entry address |
| memReqWdata | output | 141 | Entry written back on a hit |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Read data ready or write done |
| memRspRdata | input | 141 | Entry read from memory |
| doneValid | output | 1 | Result pulse |
| doneHit | output | 1 | Key matched and entry updated |
| doneMiss | output | 1 | No session, send to classifier |
| doneErr | output | 1 | Read budget exhausted |
| doneState | output | 16 | Updated state on a hit |
| doneReads | output | 4 | Chain reads used |

## Verification
The walk is tried on chains of depth 0, 1, 2, 3, 4, 6, 8, 9 and 12. The match is placed at the head, in the middle and at the tail, and some chains have no match at all. This separates hits by position, misses at a null pointer, misses at an empty bucket, and aborts at the read budget, including the match-on-read-8 boundary and a match that sits beyond that budget. One chain has an invalid entry in the middle, to show that a cleared valid bit ends the walk before the stored match is reached. State values are chosen to show the plain increment, the step up to 0xFFF, and saturation with the top nibble preserved. The memory model holds ready low for two cycles on each request and uses separate read and write latencies, which exercises the request hold and the response wait.

// File: rtl/slk_pkg.sv
`timescale 1ns/1ps
package slk_pkg;
  localparam int KEY_W     = 104;
  localparam int STATE_W   = 16;
  localparam int HITCNT_W  = 12;
  localparam int PTR_W     = 20;
  localparam int IDX_W     = 16;
  localparam int ENTRY_W   = 1 + KEY_W + STATE_W + PTR_W;
  localparam int NEXT_LSB  = 0;
  localparam int STATE_LSB = PTR_W;
  localparam int KEY_LSB   = PTR_W + STATE_W;
  localparam int VALID_BIT = ENTRY_W - 1;

  typedef struct packed {
    logic loadKey;
    logic loadBucket;
    logic loadEntry;
    logic loadNext;
    logic clrCount;
    logic incCount;
  } slkStrobes_t;

  typedef enum logic [1:0] {RES_NONE, RES_HIT, RES_MISS, RES_ERR} slkResult_t;
endpackage

// File: rtl/slkCrcHash.sv
`timescale 1ns/1ps
module slkCrcHash #(
  parameter int KEY_W = 104,
  parameter int IDX_W = 16,
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic [KEY_W-1:0] key,
  output logic [IDX_W-1:0] idx
);
  localparam int NBYTES = KEY_W / 8;

  function automatic logic [IDX_W-1:0] crcIndex(input logic [KEY_W-1:0] k);
    logic [31:0] c;
    c = '1;
    for (int b = 0; b < NBYTES; b++) begin
      c = c ^ {24'd0, k[8*b +: 8]};
      for (int j = 0; j < 8; j++) begin
        c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
      end
    end
    c = ~c;
    return c[IDX_W-1:0];
  endfunction

  always_comb idx = crcIndex(key);
endmodule

// File: rtl/slkDatapath.sv
`timescale 1ns/1ps
module slkDatapath
  import slk_pkg::*;
#(
  parameter int MAX_READS = 8,
  localparam int CNT_W = $clog2(MAX_READS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  slkStrobes_t        st,
  input  logic [KEY_W-1:0]   reqKey,
  input  logic [ENTRY_W-1:0] memRspRdata,
  output logic [PTR_W-1:0]   memReqAddr,
  output logic [ENTRY_W-1:0] memReqWdata,
  output logic [STATE_W-1:0] newState,
  output logic [CNT_W-1:0]   readCnt,
  output logic               entryValid,
  output logic               keyMatch,
  output logic               nextNull,
  output logic               countAtMax
);
  logic [KEY_W-1:0]   keyReg;
  logic [PTR_W-1:0]   addrReg;
  logic [ENTRY_W-1:0] entryReg;
  logic [CNT_W-1:0]   cntReg;
  logic [IDX_W-1:0]   bucketIdx;

  logic [KEY_W-1:0]    eKey;
  logic [STATE_W-1:0]  eState;
  logic [PTR_W-1:0]    eNext;
  logic [HITCNT_W-1:0] hitLow;

  slkCrcHash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash (
    .key(keyReg),
    .idx(bucketIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg   <= '0;
      addrReg  <= '0;
      entryReg <= '0;
      cntReg   <= '0;
    end else begin
      if (st.loadKey)    keyReg   <= reqKey;
      if (st.loadBucket) addrReg  <= {{(PTR_W-IDX_W){1'b0}}, bucketIdx};
      else if (st.loadNext) addrReg <= eNext;
      if (st.loadEntry)  entryReg <= memRspRdata;
      if (st.clrCount)   cntReg   <= '0;
      else if (st.incCount) cntReg <= cntReg + 1'b1;
    end
  end

  always_comb begin
    eKey   = entryReg[KEY_LSB +: KEY_W];
    eState = entryReg[STATE_LSB +: STATE_W];
    eNext  = entryReg[NEXT_LSB +: PTR_W];
    hitLow = eState[HITCNT_W-1:0];
    if (hitLow != {HITCNT_W{1'b1}}) hitLow = hitLow + 1'b1;
    newState = {eState[STATE_W-1:HITCNT_W], hitLow};
  end

  assign memReqAddr  = addrReg;
  assign memReqWdata = {1'b1, eKey, newState, eNext};
  assign readCnt     = cntReg;
  assign entryValid  = entryReg[VALID_BIT];
  assign keyMatch    = (eKey == keyReg);
  assign nextNull    = (eNext == '0);
  assign countAtMax  = (cntReg == CNT_W'(MAX_READS));
endmodule

// File: rtl/slkControl.sv
`timescale 1ns/1ps
module slkControl
  import slk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        entryValid,
  input  logic        keyMatch,
  input  logic        nextNull,
  input  logic        countAtMax,
  output slkStrobes_t st,
  output logic        memReqValid,
  output logic        memReqWrite,
  output logic        busy,
  output logic        doneValid,
  output logic        doneHit,
  output logic        doneMiss,
  output logic        doneErr
);
  typedef enum logic [2:0] {
    S_IDLE, S_HASH, S_RDREQ, S_RDWAIT, S_EVAL, S_WRREQ, S_WRWAIT, S_DONE
  } slkState_t;

  slkState_t  state, stateNext;
  slkResult_t res, resNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      res   <= RES_NONE;
    end else begin
      state <= stateNext;
      res   <= resNext;
    end
  end

  always_comb begin
    stateNext   = state;
    resNext     = res;
    st          = '0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    unique case (state)
      S_IDLE: if (reqValid) begin
        st.loadKey  = 1'b1;
        st.clrCount = 1'b1;
        resNext     = RES_NONE;
        stateNext   = S_HASH;
      end
      S_HASH: begin
        st.loadBucket = 1'b1;
        stateNext     = S_RDREQ;
      end
      S_RDREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) begin
          st.incCount = 1'b1;
          stateNext   = S_RDWAIT;
        end
      end
      S_RDWAIT: if (memRspValid) begin
        st.loadEntry = 1'b1;
        stateNext    = S_EVAL;
      end
      S_EVAL: begin
        if (!entryValid) begin
          resNext = RES_MISS; stateNext = S_DONE;
        end else if (keyMatch) begin
          stateNext = S_WRREQ;
        end else if (nextNull) begin
          resNext = RES_MISS; stateNext = S_DONE;
        end else if (countAtMax) begin
          resNext = RES_ERR; stateNext = S_DONE;
        end else begin
          st.loadNext = 1'b1;
          stateNext   = S_RDREQ;
        end
      end
      S_WRREQ: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) stateNext = S_WRWAIT;
      end
      S_WRWAIT: if (memRspValid) begin
        resNext   = RES_HIT;
        stateNext = S_DONE;
      end
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy      = (state != S_IDLE);
  assign doneValid = (state == S_DONE);
  assign doneHit   = doneValid && (res == RES_HIT);
  assign doneMiss  = doneValid && (res == RES_MISS);
  assign doneErr   = doneValid && (res == RES_ERR);
endmodule

// File: rtl/sessionLookup.sv
`timescale 1ns/1ps
module sessionLookup
  import slk_pkg::*;
#(
  parameter int MAX_READS = 8,
  localparam int CNT_W = $clog2(MAX_READS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [KEY_W-1:0]   reqKey,
  output logic               busy,
  output logic               memReqValid,
  output logic               memReqWrite,
  output logic [PTR_W-1:0]   memReqAddr,
  output logic [ENTRY_W-1:0] memReqWdata,
  input  logic               memReqReady,
  input  logic               memRspValid,
  input  logic [ENTRY_W-1:0] memRspRdata,
  output logic               doneValid,
  output logic               doneHit,
  output logic               doneMiss,
  output logic               doneErr,
  output logic [STATE_W-1:0] doneState,
  output logic [CNT_W-1:0]   doneReads
);
  slkStrobes_t st;
  logic entryValid, keyMatch, nextNull, countAtMax;

  slkControl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .entryValid(entryValid), .keyMatch(keyMatch),
    .nextNull(nextNull), .countAtMax(countAtMax),
    .st(st), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .busy(busy), .doneValid(doneValid), .doneHit(doneHit),
    .doneMiss(doneMiss), .doneErr(doneErr)
  );

  slkDatapath #(.MAX_READS(MAX_READS)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqKey(reqKey),
    .memRspRdata(memRspRdata), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .newState(doneState),
    .readCnt(doneReads), .entryValid(entryValid),
    .keyMatch(keyMatch), .nextNull(nextNull), .countAtMax(countAtMax)
  );
endmodule

// File: rtl/slkChecker.sv
`timescale 1ns/1ps
module slkChecker #(
  parameter int MAX_READS = 8,
  parameter int PTR_W = 20,
  localparam int CNT_W = $clog2(MAX_READS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             memReqValid,
  input logic             memReqWrite,
  input logic [PTR_W-1:0] memReqAddr,
  input logic             memReqReady,
  input logic             doneValid,
  input logic             doneHit,
  input logic             doneMiss,
  input logic             doneErr,
  input logic [CNT_W-1:0] doneReads
);
  logic wroteSeen;

  always_ff @(posedge clk) begin
    if (!rstN) wroteSeen <= 1'b0;
    else if (doneValid) wroteSeen <= 1'b0;
    else if (memReqValid && memReqReady && memReqWrite) wroteSeen <= 1'b1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqWrite));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid && !busy);

  // R9
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $countones({doneHit, doneMiss, doneErr}) == 1);

  // R6
  miss_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && !doneHit |-> !wroteSeen);

  // R4
  hit_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneHit |-> wroteSeen);

  // R7
  read_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneReads <= CNT_W'(MAX_READS)) && (!doneErr || doneReads == CNT_W'(MAX_READS)));
endmodule

bind sessionLookup slkChecker #(.MAX_READS(MAX_READS), .PTR_W(slk_pkg::PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .memReqValid(memReqValid),
  .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqReady(memReqReady),
  .doneValid(doneValid), .doneHit(doneHit), .doneMiss(doneMiss),
  .doneErr(doneErr), .doneReads(doneReads)
);

// File: tb/sessionLookup_tb.sv
`timescale 1ns/1ps
module sessionLookup_tb;
  localparam int RD_LAT = 295;
  localparam int WR_LAT = 53;
  localparam int NVEC   = 11;

  // {depth, matchPos, invalidPos, state}
  localparam logic [27:0] VEC [0:NVEC-1] = '{
    {4'd1,  4'd1,  4'd0, 16'h0005},
    {4'd3,  4'd3,  4'd0, 16'hA123},
    {4'd6,  4'd6,  4'd0, 16'h5FFF},
    {4'd6,  4'd0,  4'd0, 16'h0000},
    {4'd0,  4'd0,  4'd0, 16'h0000},
    {4'd4,  4'd2,  4'd0, 16'h0FFE},
    {4'd8,  4'd8,  4'd0, 16'h1000},
    {4'd9,  4'd0,  4'd0, 16'h0000},
    {4'd12, 4'd10, 4'd0, 16'h0000},
    {4'd2,  4'd0,  4'd0, 16'h0000},
    {4'd4,  4'd4,  4'd2, 16'h0042}
  };

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0;
  logic [103:0] reqKey = '0;
  logic busy, memReqValid, memReqWrite, doneValid, doneHit, doneMiss, doneErr;
  logic [19:0] memReqAddr;
  logic [140:0] memReqWdata, memRspRdata;
  logic memReqReady, memRspValid;
  logic [15:0] doneState;
  logic [3:0] doneReads;

  int checks = 0;
  int fails = 0;
  int rdCnt, wrCnt;
  logic [19:0] firstAddr;
  logic [140:0] mem [int unsigned];

  always #2.5 clk = ~clk;

  sessionLookup u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKey(reqKey), .busy(busy),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memRspRdata(memRspRdata), .doneValid(doneValid), .doneHit(doneHit),
    .doneMiss(doneMiss), .doneErr(doneErr), .doneState(doneState), .doneReads(doneReads)
  );

  function automatic logic [15:0] bucketOf(input logic [103:0] k);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 104; i++) begin
      logic fb;
      fb = c[0] ^ k[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return ~c[15:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: ready held low two cycles, then separate read/write latency
  initial begin
    memReqReady = 0; memRspValid = 0; memRspRdata = '0;
    forever begin
      @(negedge clk);
      memRspValid = 0;
      if (memReqValid) begin
        logic [19:0] a;
        logic wr;
        logic [140:0] wd;
        repeat (2) @(negedge clk);
        memReqReady = 1;
        a = memReqAddr; wr = memReqWrite; wd = memReqWdata;
        @(negedge clk);
        memReqReady = 0;
        if (wr) begin
          mem[a] = wd; wrCnt++;
          repeat (WR_LAT - 1) @(negedge clk);
        end else begin
          rdCnt++;
          if (rdCnt == 1) firstAddr = a;
          repeat (RD_LAT - 1) @(negedge clk);
          memRspRdata = mem.exists(a) ? mem[a] : '0;
        end
        memRspValid = 1;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic doLookup(input logic [103:0] k);
    rdCnt = 0; wrCnt = 0; firstAddr = '1;
    @(negedge clk); reqValid = 1; reqKey = k;
    @(negedge clk); reqValid = 0;
    while (!doneValid) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!busy && !doneValid && !memReqValid, "R1 in reset", {busy, doneValid, memReqValid}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !doneValid && !memReqValid, "R1 after reset", {busy, doneValid, memReqValid}, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] depth, mpos, ipos;
      logic [15:0] st0, expSt;
      logic [103:0] key;
      logic [19:0] cur, nxt, matchAddr;
      int expReads, p;
      int expRes; // 1 hit, 2 miss, 3 err
      {depth, mpos, ipos, st0} = VEC[v];
      key = {32'hC0A8_0000 + 32'(v), 32'h0A00_0001 + 32'(v * 97), 16'(1024 + v), 16'd443, 8'(6 + v)};
      mem.delete();
      cur = {4'd0, bucketOf(key)};
      matchAddr = '0;
      for (int q = 1; q <= int'(depth); q++) begin
        logic [103:0] ek;
        nxt = (q == int'(depth)) ? 20'd0 : 20'h10000 + 20'(v * 16 + q);
        ek  = (q == int'(mpos)) ? key : key ^ (104'(q) << 40);
        mem[cur] = {(q != int'(ipos)), ek, st0, nxt};
        if (q == int'(mpos)) matchAddr = cur;
        cur = nxt;
      end
      // expected walk from the requirements
      expReads = 0; p = 1; expRes = 0;
      while (expRes == 0) begin
        expReads++;
        if (p > int'(depth) || p == int'(ipos)) expRes = 2;
        else if (p == int'(mpos)) expRes = 1;
        else if (p == int'(depth)) expRes = 2;
        else if (expReads == 8) expRes = 3;
        else p++;
      end
      expSt = {st0[15:12], (st0[11:0] == 12'hFFF) ? st0[11:0] : st0[11:0] + 12'd1};

      doLookup(key);
      chk({doneHit, doneMiss, doneErr} == 3'(1 << (3 - expRes)), "R6/R7 result kind",
          {doneHit, doneMiss, doneErr}, 3'(1 << (3 - expRes)));
      chk(doneReads == 4'(expReads), "R3 chain reads", doneReads, expReads);
      chk(int'(doneReads) == rdCnt, "R10 reads vs issued", doneReads, rdCnt);
      chk(firstAddr == {4'd0, bucketOf(key)}, "R2 bucket address", firstAddr, bucketOf(key));
      if (expRes == 1) begin
        chk(doneState == expSt, "R5 updated state", doneState, expSt);
        chk(wrCnt == 1 && mem[matchAddr][35:20] == expSt && mem[matchAddr][139:36] == key
            && mem[matchAddr][140], "R4 write-back", mem[matchAddr][63:0], {key[27:0], expSt, 20'h0});
      end else begin
        chk(wrCnt == 0, "R6 no write on miss/err", wrCnt, 0);
      end
      @(negedge clk);
      chk(!busy && !doneValid, "R9 pulse ends", {busy, doneValid}, 0);
    end

    // directed: a request held high during a walk does not restart it (R9 busy)
    begin
      logic [103:0] k2;
      k2 = 104'h1234_5678_9ABC_DEF0_1122_3344_55;
      mem.delete();
      mem[{4'd0, bucketOf(k2)}] = {1'b1, k2, 16'hF00F, 20'd0};
      rdCnt = 0; wrCnt = 0;
      @(negedge clk); reqValid = 1; reqKey = k2;
      repeat (20) @(negedge clk);
      reqKey = ~k2;
      while (!doneValid) @(negedge clk);
      reqValid = 0;
      chk(doneHit && doneState == 16'hF010, "R5 held request hit", doneState, 16'hF010);
      chk(rdCnt == 1, "R8 single read for held request", rdCnt, 1);
      repeat (2) @(negedge clk);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule